// File: doc/BRIEF.md
# Two-Mode MDIO Management Master

This block is the management-bus master that reads and writes PHY registers over a two-wire serial link. It divides the system clock down to produce MDC. It drives the bidirectional MDIO line through separate data-out, output-enable and data-in pins, so the pad tri-state buffer sits outside the block. A host presents one request at a time. Each request carries a read/write flag, a 5-bit port address, a 32-bit register selector and 16 bits of write data. The block answers with a one-cycle done pulse, the read data and an error flag.

There are two kinds of access. In direct mode, one frame carries a 5-bit register number. Setting bit 30 of the selector picks extended mode. The block then sends an address frame on its own first. That frame loads the 16-bit register address into the device named by selector bits 20:16. A read or write frame follows, with its own start code and opcode set. All fields go out MSB first. MDIO changes on the falling edge of MDC, and read data is sampled on the rising edge.

Top module: `mdio_master`

## Requirements
- R1: Every frame starts with 32 bit times in which the master drives MDIO high (mdio_oe=1, mdio_o=1).
- R2: A direct frame (selector bit 30 clear) sends start bits 0,1, then opcode 1,0 for a read or 0,1 for a write, then the 5-bit port address, then selector bits 4:0. Selector bits 31 and 29:5 have no effect in this mode.
- R3: When selector bit 30 is set, an address frame goes out first. It carries start 0,0, opcode 0,0, the port, selector bits 20:16, turnaround 1,0 and selector bits 15:0. One released bit time follows. Then a second frame goes out with start 0,0, opcode 1,1 for a read or 0,1 for a write, the port and selector bits 20:16.
- R4: In a write frame, the master drives turnaround 1,0 and then the 16 write-data bits, MSB first.
- R5: In a read frame, the master releases MDIO (mdio_oe=0) from the first turnaround bit onward. It samples 16 data bits, MSB first, on MDC rising edges and returns them on rsp_rdata. A write returns rsp_rdata equal to zero.
- R6: rsp_err is 1 exactly when the second turnaround bit of a read frame is sampled as 1. Writes report rsp_err=0.
- R7: Every frame ends with one bit time in which MDIO is released. rsp_done pulses for exactly one clock, on the clock edge where MDC falls at the end of that released bit time of the final frame.
- R8: MDC stays high for HALF_DIV clock cycles and low for HALF_DIV clock cycles. mdio_o and mdio_oe change only on clock edges where MDC falls.
- R9: busy is 1 from the clock after a request is accepted until the edge that raises rsp_done. A req_valid seen while busy is ignored and starts no transfer.
- R10: During and after reset, mdio_oe, busy and rsp_done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | 5 | PHY port address |
| req_sel | input | 32 | Register selector; bit 30 selects extended mode |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transfer in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, held until the next completion |
| rsp_err | output | 1 | Read turnaround error, held with rsp_rdata |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value from the pad |

## Verification
The first bit time starts at the first MDC falling edge after the request is accepted. A direct access then spans 65 MDC periods and an extended access 130. The bench follows MDC edges rather than counting clocks. It samples mdio_oe and mdio_o at each MDC rising edge and drives PHY read bits just after each falling edge. Once the last falling edge is seen, rsp_done is due on that same clock edge. The bench therefore checks done, busy, data and error at the next clock low phase, and checks that done has cleared one clock later. The MDC half period is measured in clock low phases, which gives HALF_DIV plus one samples across one high phase.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int EXT_SEL_BIT = 30;
    localparam int FRAME_W     = 64;
    localparam int POS_TA1     = 46;
    localparam int POS_TA2     = 47;
    localparam int POS_DATA    = 48;
    localparam int POS_IDLE    = 64;
    localparam int POS_W       = 7;
    localparam int PREAMBLE_N  = 32;

    typedef enum logic { SQ_IDLE = 1'b0, SQ_RUN = 1'b1 } seq_state_e;
    typedef enum logic { PH_ADDR = 1'b0, PH_DATA = 1'b1 } phase_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF_DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } cg_t;

    cg_t  cg_q, cg_d;
    logic wrap;

    always_comb begin
        cg_d = cg_q;
        wrap = (cg_q.cnt == LAST);
        if (wrap) begin
            cg_d.cnt = '0;
            cg_d.mdc = ~cg_q.mdc;
        end else begin
            cg_d.cnt = cg_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cg_q <= '0;
        else        cg_q <= cg_d;
    end

    assign mdc      = cg_q.mdc;
    assign rise_stb = wrap & ~cg_q.mdc;
    assign fall_stb = wrap &  cg_q.mdc;

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb));
    assert_mdc_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $past(rise_stb));
    assert_mdc_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc) |-> $past(fall_stb));
endmodule

// File: rtl/mdio_framer.sv
module mdio_framer
    import mdio_pkg::*;
(
    input  logic                ext,
    input  phase_e              phase,
    input  logic                write,
    input  logic [4:0]          port,
    input  logic [31:0]         sel,
    input  logic [15:0]         wdata,
    output logic [FRAME_W-1:0]  frame,
    output logic                rd_frame
);
    logic [1:0]  st_bits;
    logic [1:0]  op_bits;
    logic [4:0]  fld;
    logic [15:0] payload;

    always_comb begin
        st_bits = ext ? 2'b00 : 2'b01;
        if (phase == PH_ADDR)  op_bits = 2'b00;
        else if (write)        op_bits = 2'b01;
        else if (ext)          op_bits = 2'b11;
        else                   op_bits = 2'b10;
        fld      = ext ? sel[20:16] : sel[4:0];
        payload  = (phase == PH_ADDR) ? sel[15:0] : wdata;
        rd_frame = (phase == PH_DATA) && !write;
        frame    = {{PREAMBLE_N{1'b1}}, st_bits, op_bits, port, fld, 2'b10, payload};
    end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdc,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [4:0]  req_port,
    input  logic [31:0] req_sel,
    input  logic [15:0] req_wdata,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        busy,
    output logic        rsp_done,
    output logic [15:0] rsp_rdata,
    output logic        rsp_err
);
    typedef struct packed {
        seq_state_e        state;
        phase_e            phase;
        logic              started;
        logic [POS_W-1:0]  pos;
        logic              write;
        logic              ext;
        logic [4:0]        port;
        logic [31:0]       sel;
        logic [15:0]       wdata;
        logic [15:0]       shift;
        logic              err;
        logic              line_o;
        logic              line_oe;
        logic              done;
        logic [15:0]       rdata;
        logic              rerr;
    } sq_t;

    sq_t sq_q, sq_d;

    logic               frame_end;
    phase_e             phase_nx;
    logic [FRAME_W-1:0] frame;
    logic               rd_frame;
    logic [5:0]         bit_idx;

    assign frame_end = (sq_q.state == SQ_RUN) && sq_q.started && fall_stb
                       && (sq_q.pos == POS_W'(POS_IDLE));
    assign phase_nx  = (frame_end && sq_q.phase == PH_ADDR) ? PH_DATA : sq_q.phase;

    mdio_framer u_framer (
        .ext      (sq_q.ext),
        .phase    (phase_nx),
        .write    (sq_q.write),
        .port     (sq_q.port),
        .sel      (sq_q.sel),
        .wdata    (sq_q.wdata),
        .frame    (frame),
        .rd_frame (rd_frame)
    );

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        bit_idx   = '0;
        case (sq_q.state)
            SQ_IDLE: begin
                if (req_valid) begin
                    sq_d.state   = SQ_RUN;
                    sq_d.write   = req_write;
                    sq_d.ext     = req_sel[EXT_SEL_BIT];
                    sq_d.port    = req_port;
                    sq_d.sel     = req_sel;
                    sq_d.wdata   = req_wdata;
                    sq_d.phase   = req_sel[EXT_SEL_BIT] ? PH_ADDR : PH_DATA;
                    sq_d.started = 1'b0;
                    sq_d.pos     = '0;
                    sq_d.shift   = '0;
                    sq_d.err     = 1'b0;
                end
            end
            default: begin
                if (fall_stb) begin
                    if (!sq_q.started) begin
                        sq_d.started = 1'b1;
                        sq_d.pos     = '0;
                    end else if (sq_q.pos == POS_W'(POS_IDLE)) begin
                        if (sq_q.phase == PH_ADDR) begin
                            sq_d.phase = PH_DATA;
                            sq_d.pos   = '0;
                        end else begin
                            sq_d.state   = SQ_IDLE;
                            sq_d.started = 1'b0;
                            sq_d.done    = 1'b1;
                            sq_d.rdata   = sq_q.shift;
                            sq_d.rerr    = sq_q.err;
                        end
                    end else begin
                        sq_d.pos = sq_q.pos + 1'b1;
                    end
                end
                if (rise_stb && sq_q.started && sq_q.phase == PH_DATA && !sq_q.write) begin
                    if (sq_q.pos == POS_W'(POS_TA2)) begin
                        sq_d.err = mdio_i;
                    end else if (sq_q.pos >= POS_W'(POS_DATA) && sq_q.pos < POS_W'(POS_IDLE)) begin
                        sq_d.shift = {sq_q.shift[14:0], mdio_i};
                    end
                end
            end
        endcase

        // Line drive for the bit time that begins at this edge
        sq_d.line_o  = 1'b0;
        sq_d.line_oe = 1'b0;
        if (sq_d.state == SQ_RUN && sq_d.started && sq_d.pos < POS_W'(POS_IDLE)) begin
            bit_idx = 6'(6'd63 - sq_d.pos[5:0]);
            if (!(rd_frame && sq_d.pos >= POS_W'(POS_TA1))) begin
                sq_d.line_oe = 1'b1;
                sq_d.line_o  = frame[bit_idx];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q       <= '0;
            sq_q.state <= SQ_IDLE;
            sq_q.phase <= PH_DATA;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign mdio_o    = sq_q.line_o;
    assign mdio_oe   = sq_q.line_oe;
    assign busy      = (sq_q.state == SQ_RUN);
    assign rsp_done  = sq_q.done;
    assign rsp_rdata = sq_q.rdata;
    assign rsp_err   = sq_q.rerr;

    assert_line_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_o != $past(mdio_o) || mdio_oe != $past(mdio_oe)) |-> (!mdc && $past(mdc)));
    assert_preamble_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.started && sq_q.pos < POS_W'(PREAMBLE_N)) |-> (mdio_oe && mdio_o));
    assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.started && sq_q.phase == PH_DATA && !sq_q.write
         && sq_q.pos >= POS_W'(POS_TA1)) |-> !mdio_oe);
    assert_idle_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.started && sq_q.pos == POS_W'(POS_IDLE)) |-> !mdio_oe);
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (!busy && $past(busy)));
    assert_write_no_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && sq_q.write) |-> !rsp_err);
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int HALF_DIV = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [4:0]  req_port,
    input  logic [31:0] req_sel,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        rsp_done,
    output logic [15:0] rsp_rdata,
    output logic        rsp_err,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic rise_stb;
    logic fall_stb;

    mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_stb  (rise_stb),
        .fall_stb  (fall_stb),
        .mdc       (mdc),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_port  (req_port),
        .req_sel   (req_sel),
        .req_wdata (req_wdata),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .busy      (busy),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> (!mdio_oe && !busy && !rsp_done));
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
    localparam int HALF = 3;

    typedef struct packed {
        logic        wr;
        logic [31:0] sel;
        logic [4:0]  port;
        logic [15:0] wdata;
        logic [15:0] phy;
        logic        tabad;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h0000_0003, 5'h11, 16'hA5C3, 16'h0000, 1'b0},
        '{1'b0, 32'h0000_001F, 5'h01, 16'h0000, 16'h1234, 1'b0},
        '{1'b1, 32'h4007_BEEF, 5'h03, 16'h0F0F, 16'h0000, 1'b0},
        '{1'b0, 32'h401F_8001, 5'h1E, 16'h0000, 16'hCAFE, 1'b0},
        '{1'b0, 32'h0000_000A, 5'h00, 16'h0000, 16'h5555, 1'b1},
        '{1'b0, 32'h4012_0000, 5'h15, 16'h0000, 16'hFFFF, 1'b1},
        '{1'b1, 32'hBF1F_0009, 5'h0A, 16'h0001, 16'h0000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_port = '0;
    logic [31:0] req_sel = '0;
    logic [15:0] req_wdata = '0;
    logic        mdio_i = 1'b1;
    logic        busy, rsp_done, rsp_err, mdc, mdio_o, mdio_oe;
    logic [15:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mdio_master #(.HALF_DIV(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_port(req_port), .req_sel(req_sel), .req_wdata(req_wdata),
        .busy(busy), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected {oe, o} at bit time k of a whole transfer
    function automatic logic [1:0] exp_line(vec_t v, int k);
        int   p = k % 65;
        logic ext = v.sel[30];
        logic addr_fr = ext && (k < 65);
        logic rdf = !addr_fr && !v.wr;
        logic [63:0] w;
        logic [1:0] op;
        if (addr_fr)      op = 2'b00;
        else if (v.wr)    op = 2'b01;
        else if (ext)     op = 2'b11;
        else              op = 2'b10;
        w = {32'hFFFF_FFFF, (ext ? 2'b00 : 2'b01), op, v.port,
             (ext ? v.sel[20:16] : v.sel[4:0]), 2'b10,
             (addr_fr ? v.sel[15:0] : v.wdata)};
        if (p >= 64)             return 2'b00;
        if (rdf && p >= 46)      return 2'b00;
        return {1'b1, w[63-p]};
    endfunction

    task automatic run_vec(input vec_t v, input string name);
        int n = v.sel[30] ? 130 : 65;
        int bad = -1;
        logic [1:0] got, exp, gb, eb;
        string tag;
        @(negedge clk);
        req_write = v.wr; req_port = v.port; req_sel = v.sel; req_wdata = v.wdata;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b1, "R9", {name, " busy after accept"}, 32'(busy), 32'd1);
        @(negedge mdc);
        for (int k = 0; k < n; k++) begin
            int p = k % 65;
            mdio_i = 1'b1;
            if (!v.wr && k >= n - 65) begin
                if (p == 47) mdio_i = v.tabad;
                else if (p >= 48 && p < 64) mdio_i = v.phy[63-p];
            end
            @(posedge mdc);
            got = {mdio_oe, mdio_o};
            exp = exp_line(v, k);
            if (got !== exp && bad < 0) begin bad = k; gb = got; eb = exp; end
            @(negedge mdc);
        end
        mdio_i = 1'b1;
        if (bad < 0) tag = "R1";
        else if (bad % 65 < 32) tag = "R1";
        else if (bad % 65 < 46) tag = v.sel[30] ? "R3" : "R2";
        else if (bad % 65 >= 64) tag = "R7";
        else if (v.sel[30] && bad < 65) tag = "R3";
        else tag = v.wr ? "R4" : "R5";
        chk(bad < 0, tag, $sformatf("%s line at bit %0d", name, bad), 32'(gb), 32'(eb));
        @(negedge clk);
        chk(rsp_done === 1'b1, "R7", {name, " done on final fall"}, 32'(rsp_done), 32'd1);
        chk(busy === 1'b0, "R9", {name, " busy clear at done"}, 32'(busy), 32'd0);
        chk(rsp_rdata === (v.wr ? 16'h0 : v.phy), "R5", {name, " read data"},
            32'(rsp_rdata), 32'(v.wr ? 16'h0 : v.phy));
        chk(rsp_err === (v.tabad & ~v.wr), "R6", {name, " turnaround error"},
            32'(rsp_err), 32'(v.tabad & ~v.wr));
        @(negedge clk);
        chk(rsp_done === 1'b0, "R7", {name, " done one cycle"}, 32'(rsp_done), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int n;
        bit quiet;
        repeat (3) @(negedge clk);
        // R10: state held in reset
        chk(mdio_oe === 1'b0, "R10", "oe in reset", 32'(mdio_oe), 32'd0);
        chk(busy === 1'b0, "R10", "busy in reset", 32'(busy), 32'd0);
        chk(rsp_done === 1'b0, "R10", "done in reset", 32'(rsp_done), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(mdio_oe === 1'b0 && busy === 1'b0, "R10", "idle after reset",
            32'({mdio_oe, busy}), 32'd0);

        // Vector table: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) run_vec(VECS[i], $sformatf("vec%0d", i));

        // R8: MDC high phase length
        @(posedge mdc);
        n = 0;
        do begin @(negedge clk); n++; end while (mdc);
        chk(n - 1 == HALF, "R8", "mdc high clocks", 32'(n - 1), 32'(HALF));

        // R9: a request during a transfer is ignored
        fork
            run_vec(VECS[0], "busyreq");
            begin
                repeat (30) @(negedge clk);
                req_write = 1'b0; req_sel = 32'h4001_0002; req_port = 5'h07;
                req_valid = 1'b1;
                @(negedge clk);
                req_valid = 1'b0;
            end
        join
        quiet = 1'b1;
        for (int c = 0; c < 2 * HALF * 140; c++) begin
            @(negedge clk);
            if (busy !== 1'b0 || mdio_oe !== 1'b0 || rsp_done !== 1'b0) quiet = 1'b0;
        end
        chk(quiet, "R9", "ignored request started nothing", 32'(quiet), 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule